// File: doc/BRIEF.md
# Banked Register Window

This block lets a host reach several banks of registers through an I/O window only sixteen bytes wide. The host drives a byte address, a read/write flag and two byte-lane enables on a 16-bit data bus. The top word of the window is the same in every bank. It holds the number of the bank that all other offsets currently reach. A host writes that word once to pick a bank, then reads or writes registers inside it.

Each bank has a run of plain 16-bit storage words at its lowest even offsets. A word is addressed at its even offset. Its upper byte can also be addressed alone at the odd offset directly above. One bank also carries a location made of two unrelated 8-bit registers that share a word slot. The lower byte is a write-only acknowledge strobe, and the upper byte is a readable mask byte. Reads are combinational, so data belongs to the same cycle as the address. A location that is not implemented reads as zero and ignores writes.

Top module: `bank_window`

## Requirements
- R1: After reset the selected bank is 0, every storage word and the mask byte read as 0x0000, and `ack_strobe` is 0.
- R2: The word at offset 14 is reachable in every bank. A write to it with `be[0]` set loads `wdata[2:0]` as the bank number. A write with only `be[1]` set leaves the bank unchanged. A read returns the bank number in bits 2:0 and zeros in bits 15:3.
- R3: A new bank number is used from the access that follows the bank write, and the `bank` output changes only through such a write.
- R4: In banks 0 to 3, the words at offsets 0, 2, 4, 6 and 8 are independent 16-bit storage words, separate in each bank.
- R5: On a write, `be[0]` enables bits 7:0 and `be[1]` enables bits 15:8. A byte whose enable is low keeps its value.
- R6: When `addr[0]` is 1 the access reaches the upper byte of the word at `addr` minus one. Only `be[1]` can write, and the lower byte is never changed.
- R7: While `cs` is high and `wr` is low, `rdata` gives the full addressed word in the same cycle. At all other times `rdata` is 0x0000.
- R8: These locations read as 0x0000 and ignore writes: offset 10 in any bank, offset 12 outside bank 2, and every offset except 14 while the bank number is 4 to 7.
- R9: In bank 2, a write with `be[0]` at offset 12 puts `wdata[7:0]` on `ack_strobe` for the next cycle only, and the acknowledge byte reads as zero. A write with `be[1]` at offset 12 or 13 stores `wdata[15:8]` as the mask byte, which reads back in bits 15:8.
- R10: With `cs` low, nothing changes and `ack_strobe` stays 0, whatever `wr`, `addr`, `be` and `wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Access strobe, one access per cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Byte offset in the window |
| be | input | 2 | Byte-lane enables, bit 0 = low byte |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational |
| bank | output | 3 | Currently selected bank number |
| ack_strobe | output | 8 | One-cycle acknowledge byte from bank 2 |

## Verification
The bench builds the block with its defaults: four banks, five storage words per bank, and the byte pair at offset 12 of bank 2. These values leave offset 10 as a gap in every bank. Because the bank field is three bits wide, the host can also select banks 4 to 7, which have no storage, so the bench can show that those banks read zero and drop writes. The bench can also show that switching back restores the contents of an implemented bank.

// File: rtl/bw_pkg.sv
package bw_pkg;
  localparam int WIN_BYTES = 16;
  localparam int WIN_AW    = $clog2(WIN_BYTES);
  localparam int WORD_W    = 16;
  localparam int LANES     = WORD_W / 8;
  localparam int WIDX_W    = WIN_AW - 1;
  localparam int LAST_WORD = WIN_BYTES / LANES - 1;
  localparam int BANK_W    = 3;

  typedef logic [WIDX_W-1:0] widx_t;
  typedef logic [BANK_W-1:0] bank_t;

  typedef struct packed {
    logic             rd;
    logic             wr;
    logic             shared;
    logic             store;
    logic             pair;
    widx_t            word;
    logic [LANES-1:0] lanes;
  } win_dec_t;
endpackage

// File: rtl/bw_decode.sv
module bw_decode
  import bw_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int REG_WORDS = 5,
  parameter int PAIR_BANK = 2,
  parameter int PAIR_WORD = 6
) (
  input  logic              cs,
  input  logic              wr,
  input  logic [WIN_AW-1:0] addr,
  input  logic [LANES-1:0]  be,
  input  bank_t             bank,
  output win_dec_t          dec
);
  localparam logic [BANK_W:0]   BANK_LIM  = (BANK_W+1)'(NUM_BANKS);
  localparam logic [WIDX_W:0]   WORD_LIM  = (WIDX_W+1)'(REG_WORDS);
  localparam widx_t             SEL_WORD  = WIDX_W'(LAST_WORD);
  localparam widx_t             PAIR_W    = WIDX_W'(PAIR_WORD);
  localparam bank_t             PAIR_B    = BANK_W'(PAIR_BANK);

  logic             bank_ok;
  logic [LANES-1:0] odd_mask;

  always_comb begin
    dec.word   = addr[WIN_AW-1:1];
    bank_ok    = {1'b0, bank} < BANK_LIM;
    odd_mask   = {{(LANES-1){1'b1}}, ~addr[0]};
    dec.lanes  = be & odd_mask;
    dec.rd     = cs & ~wr;
    dec.wr     = cs & wr;
    dec.shared = (dec.word == SEL_WORD);
    dec.store  = ~dec.shared & bank_ok & ({1'b0, dec.word} < WORD_LIM);
    dec.pair   = ~dec.shared & (bank == PAIR_B) & (dec.word == PAIR_W);
  end
endmodule

// File: rtl/bw_bank_sel.sv
module bw_bank_sel
  import bw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  bank_t new_bank,
  output bank_t bank
);
  bank_t bank_q, bank_nxt;

  always_comb begin
    bank_nxt = bank_q;
    if (load) bank_nxt = new_bank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank_q <= '0;
    else if (load) bank_q <= bank_nxt;
  end

  assign bank = bank_q;
endmodule

// File: rtl/bw_store.sv
module bw_store
  import bw_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int REG_WORDS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  bank_t             bank,
  input  widx_t             word,
  input  logic [LANES-1:0]  lanes,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_data
);
  localparam int CELLS = NUM_BANKS * REG_WORDS;

  int                       sel_idx;
  logic [CELLS*WORD_W-1:0]  flat;

  always_comb sel_idx = int'(bank) * REG_WORDS + int'(word);

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    logic [WORD_W-1:0] q, nxt;
    logic              sel, en;

    always_comb begin
      sel = wr_hit && (sel_idx == c);
      nxt = q;
      for (int l = 0; l < LANES; l++) begin
        if (sel && lanes[l]) nxt[l*8 +: 8] = wdata[l*8 +: 8];
      end
      en = sel && (|lanes);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= nxt;
    end

    assign flat[c*WORD_W +: WORD_W] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < CELLS; c++) begin
      if (sel_idx == c) rd_data = flat[c*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/bw_pair.sv
module bw_pair (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [1:0]  lanes,
  input  logic [15:0] wdata,
  output logic [7:0]  mask,
  output logic [7:0]  ack
);
  logic [7:0] mask_q, mask_nxt, ack_q, ack_nxt;
  logic       mask_en;

  always_comb begin
    mask_en  = wr_hit & lanes[1];
    mask_nxt = mask_en ? wdata[15:8] : mask_q;
    ack_nxt  = (wr_hit & lanes[0]) ? wdata[7:0] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= '0;
    else        ack_q <= ack_nxt;
  end

  assign mask = mask_q;
  assign ack  = ack_q;
endmodule

// File: rtl/bank_window.sv
module bank_window
  import bw_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int REG_WORDS = 5,
  parameter int PAIR_BANK = 2,
  parameter int PAIR_WORD = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic [WIN_AW-1:0] addr,
  input  logic [LANES-1:0]  be,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [BANK_W-1:0] bank,
  output logic [7:0]        ack_strobe
);
  logic              rst_meta, rst_q;
  win_dec_t          dec;
  bank_t             bank_cur;
  logic [WORD_W-1:0] store_rd;
  logic [7:0]        mask_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  bw_decode #(
    .NUM_BANKS(NUM_BANKS), .REG_WORDS(REG_WORDS),
    .PAIR_BANK(PAIR_BANK), .PAIR_WORD(PAIR_WORD)
  ) u_dec (
    .cs(cs), .wr(wr), .addr(addr), .be(be), .bank(bank_cur), .dec(dec)
  );

  bw_bank_sel u_sel (
    .clk(clk), .rst_n(rst_q),
    .load(dec.wr & dec.shared & dec.lanes[0]),
    .new_bank(wdata[BANK_W-1:0]),
    .bank(bank_cur)
  );

  bw_store #(.NUM_BANKS(NUM_BANKS), .REG_WORDS(REG_WORDS)) u_store (
    .clk(clk), .rst_n(rst_q),
    .wr_hit(dec.wr & dec.store),
    .bank(bank_cur), .word(dec.word), .lanes(dec.lanes),
    .wdata(wdata), .rd_data(store_rd)
  );

  bw_pair u_pair (
    .clk(clk), .rst_n(rst_q),
    .wr_hit(dec.wr & dec.pair),
    .lanes(dec.lanes), .wdata(wdata),
    .mask(mask_byte), .ack(ack_strobe)
  );

  always_comb begin
    rdata = '0;
    if (dec.rd) begin
      if (dec.shared)     rdata = WORD_W'(bank_cur);
      else if (dec.store) rdata = store_rd;
      else if (dec.pair)  rdata = {mask_byte, 8'h00};
    end
  end

  assign bank = bank_cur;
endmodule

// File: rtl/bw_checker.sv
module bw_checker
  import bw_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int REG_WORDS = 5,
  parameter int PAIR_BANK = 2,
  parameter int PAIR_WORD = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              wr,
  input logic [WIN_AW-1:0] addr,
  input logic              be_lo,
  input logic [BANK_W-1:0] wbank,
  input logic [WORD_W-1:0] rdata,
  input logic [BANK_W-1:0] bank,
  input logic [7:0]        ack_strobe
);
  localparam logic [BANK_W:0] BANK_LIM = (BANK_W+1)'(NUM_BANKS);
  localparam widx_t           SEL_WORD = WIDX_W'(LAST_WORD);
  localparam widx_t           PAIR_W   = WIDX_W'(PAIR_WORD);
  localparam bank_t           PAIR_B   = BANK_W'(PAIR_BANK);

  logic sel_load, sel_read, pair_ack_wr, dead_read;

  always_comb begin
    sel_load    = cs && wr && (addr[WIN_AW-1:1] == SEL_WORD) && !addr[0] && be_lo;
    sel_read    = cs && !wr && (addr[WIN_AW-1:1] == SEL_WORD);
    pair_ack_wr = cs && wr && (addr[WIN_AW-1:1] == PAIR_W) && !addr[0] && be_lo
                  && (bank == PAIR_B);
    dead_read   = cs && !wr && (addr[WIN_AW-1:1] != SEL_WORD) && ({1'b0, bank} >= BANK_LIM);
  end

  a_r2_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    sel_load |=> bank == $past(wbank));

  a_r3_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_load |=> $stable(bank));

  a_r2_select_read: assert property (@(posedge clk) disable iff (!rst_n)
    sel_read |-> rdata == WORD_W'(bank));

  a_r8_dead_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dead_read |-> rdata == '0);

  a_r9_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_ack_wr |=> ack_strobe == 8'h00);

  a_r7_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && !wr) |-> rdata == '0);
endmodule

bind bank_window bw_checker #(
  .NUM_BANKS(NUM_BANKS), .REG_WORDS(REG_WORDS),
  .PAIR_BANK(PAIR_BANK), .PAIR_WORD(PAIR_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_q), .cs(cs), .wr(wr), .addr(addr), .be_lo(be[0]),
  .wbank(wdata[2:0]), .rdata(rdata), .bank(bank), .ack_strobe(ack_strobe)
);

// File: tb/sim_bank_window.sv
module sim_bank_window;
  logic        clk, rst_n, cs, wr;
  logic [3:0]  addr;
  logic [1:0]  be;
  logic [15:0] wdata, rdata;
  logic [2:0]  bank;
  logic [7:0]  ack_strobe;

  int checks = 0;
  int fails  = 0;
  bit run    = 0;

  // reference state built from the requirements
  logic [15:0] m_reg [8][8];
  logic [2:0]  m_bank;
  logic [7:0]  m_mask;
  logic [7:0]  ack_pend, ack_cur;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  bank_window u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr(addr), .be(be),
    .wdata(wdata), .rdata(rdata), .bank(bank), .ack_strobe(ack_strobe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(logic [3:0] a);
    logic [2:0] w;
    w = a[3:1];
    if (w == 3'd7)                    return {13'b0, m_bank};
    if (m_bank >= 3'd4)               return 16'h0000;
    if (w < 3'd5)                     return m_reg[m_bank][w];
    if (w == 3'd6 && m_bank == 3'd2)  return {m_mask, 8'h00};
    return 16'h0000;
  endfunction

  task automatic model_wr(logic [3:0] a, logic [1:0] b, logic [15:0] d);
    logic [1:0] ln;
    logic [2:0] w;
    w  = a[3:1];
    ln = b & (a[0] ? 2'b10 : 2'b11);
    if (w == 3'd7) begin
      if (ln[0]) m_bank = d[2:0];
    end else if (m_bank < 3'd4) begin
      if (w < 3'd5) begin
        if (ln[0]) m_reg[m_bank][w][7:0]  = d[7:0];
        if (ln[1]) m_reg[m_bank][w][15:8] = d[15:8];
      end else if (w == 3'd6 && m_bank == 3'd2) begin
        if (ln[1]) m_mask = d[15:8];
        if (ln[0]) ack_pend = d[7:0];
      end
    end
  endtask

  task automatic do_wr(logic [3:0] a, logic [1:0] b, logic [15:0] d);
    @(posedge clk); #1;
    cs = 1'b1; wr = 1'b1; addr = a; be = b; wdata = d;
    model_wr(a, b, d);
  endtask

  task automatic do_rd(logic [3:0] a, string tag);
    @(posedge clk); #1;
    cs = 1'b1; wr = 1'b0; addr = a; be = 2'b11; wdata = 16'h0;
    exp_q.push_back(exp_rd(a));
    tag_q.push_back(tag);
  endtask

  task automatic idle(bit wr_lvl, logic [3:0] a, logic [15:0] d);
    @(posedge clk); #1;
    cs = 1'b0; wr = wr_lvl; addr = a; be = 2'b11; wdata = d;
    @(negedge clk);
    chk("R7 rdata idle", rdata, 16'h0000);
  endtask

  // monitor: compares read data and the acknowledge byte mid-cycle
  always @(posedge clk) begin
    ack_cur  = ack_pend;
    ack_pend = 8'h00;
  end

  always @(negedge clk) begin
    if (run) begin
      if (cs && !wr) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R7: actual read %h expected no read", rdata);
        end else begin
          chk(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
      end
      chk("R9 ack_strobe", {8'h00, ack_strobe}, {8'h00, ack_cur});
    end
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog R1..: actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++)
      for (int w = 0; w < 8; w++) m_reg[b][w] = 16'h0;
    m_bank = 3'd0; m_mask = 8'h0; ack_pend = 8'h0; ack_cur = 8'h0;
    rst_n = 1'b0; cs = 1'b0; wr = 1'b0; addr = 4'h0; be = 2'b00; wdata = 16'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 bank after reset", {13'b0, bank}, 16'h0000);
    chk("R1 ack after reset", {8'h00, ack_strobe}, 16'h0000);
    run = 1;

    // R1: everything reads zero
    for (int w = 0; w < 8; w++) do_rd(4'(2 * w), "R1 reset read");

    // R4/R7: plain words in bank 0
    do_wr(4'd0, 2'b11, 16'h1111);
    do_wr(4'd2, 2'b11, 16'h2222);
    do_wr(4'd4, 2'b11, 16'h3333);
    do_wr(4'd6, 2'b11, 16'h4444);
    do_wr(4'd8, 2'b11, 16'h5555);
    for (int w = 0; w < 5; w++) do_rd(4'(2 * w), "R4 bank0 word");

    // R2/R3: switch to bank 1, new bank used by the very next access
    do_wr(4'd14, 2'b11, 16'h0001);
    do_rd(4'd0, "R3 next access in bank1");
    @(negedge clk);
    chk("R3 bank port", {13'b0, bank}, 16'h0001);
    do_wr(4'd0, 2'b11, 16'hABCD);
    do_wr(4'd8, 2'b11, 16'h0F0F);
    do_rd(4'd0, "R4 bank1 word0");
    do_rd(4'd8, "R4 bank1 word8");
    do_wr(4'd14, 2'b01, 16'h0000);
    do_rd(4'd0, "R4 bank0 kept");
    do_rd(4'd8, "R4 bank0 word8 kept");

    // R5: byte lanes
    do_wr(4'd2, 2'b01, 16'h00EE);
    do_rd(4'd2, "R5 low lane");
    do_wr(4'd2, 2'b10, 16'h9900);
    do_rd(4'd2, "R5 high lane");

    // R6: odd offsets reach only the upper byte
    do_wr(4'd5, 2'b11, 16'h7788);
    do_rd(4'd4, "R6 odd write both enables");
    do_rd(4'd5, "R6 odd read");
    do_wr(4'd7, 2'b01, 16'hFFFF);
    do_rd(4'd6, "R6 odd low enable ignored");

    // R2: high-lane-only bank write ignored, upper bits read zero
    do_wr(4'd14, 2'b10, 16'h0300);
    do_rd(4'd14, "R2 high lane bank write");
    do_wr(4'd14, 2'b11, 16'hFFF9);
    do_rd(4'd14, "R2 upper bits zero");

    // R8: empty bank, gap word, pair slot outside bank 2
    do_wr(4'd14, 2'b11, 16'h0007);
    do_rd(4'd0, "R8 bank7 read");
    do_wr(4'd0, 2'b11, 16'h1234);
    do_rd(4'd0, "R8 bank7 write dropped");
    do_rd(4'd14, "R8 select in bank7");
    do_wr(4'd14, 2'b11, 16'h0001);
    do_rd(4'd0, "R8 bank1 untouched");
    do_wr(4'd10, 2'b11, 16'hDEAD);
    do_rd(4'd10, "R8 gap offset");
    do_wr(4'd12, 2'b11, 16'hBEEF);
    do_rd(4'd12, "R8 pair slot bank1");

    // R9: byte pair in bank 2
    do_wr(4'd14, 2'b11, 16'h0002);
    do_wr(4'd12, 2'b01, 16'h00A5);
    do_rd(4'd12, "R9 ack reads zero");
    do_wr(4'd13, 2'b10, 16'h3C00);
    do_rd(4'd12, "R9 mask byte");
    do_wr(4'd12, 2'b11, 16'h5AC3);
    do_rd(4'd13, "R9 word write to pair");
    do_rd(4'd0, "R9 pair not in storage");

    // R10: cs low changes nothing
    idle(1'b1, 4'd0, 16'hFFFF);
    idle(1'b1, 4'd12, 16'h00FF);
    idle(1'b1, 4'd14, 16'h0005);
    do_rd(4'd0, "R10 storage unchanged");
    do_rd(4'd12, "R10 mask unchanged");
    do_rd(4'd14, "R10 bank unchanged");
    idle(1'b0, 4'd0, 16'h0000);
    @(negedge clk);
    chk("R10 bank port", {13'b0, bank}, 16'h0002);

    run = 0;
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R7: actual %0d reads pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule